// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer and Result Latch

This block is the digital half of a 4-1/2 digit dual-slope measuring converter. A fixed-length conversion cycle steps through three phases: auto-zero, signal integrate and reference de-integrate. During de-integrate the block counts clocks into a five-digit BCD counter until the analog comparator reports its zero crossing, or until the count reaches full scale. The input polarity, sampled at the close of integration, supplies the sign of the reading.

A finished result moves into display registers, together with an over-range flag and an under-range flag. A two-bit display mode selects one of three behaviours: the display updates every conversion, the display freezes on the last reading, or the display follows the running counter while de-integrate is in progress. A status output drops low for one clock whenever the display registers take a new reading. A short-integration option cuts the integrate phase to a tenth of its length and forces the sign positive. It takes effect only when the range select is also high.

Top module: `dsc_core`

## Requirements
- R1: After reset only `az_o` is high. Exactly one phase output is high at all times, and the phases always follow the order auto-zero, integrate, de-integrate, auto-zero.
- R2: Integrate lasts INT_CYC clocks. Integrate starts exactly AZ_MIN_CYC + INT_CYC + 20000 clocks after the previous integrate started, and auto-zero fills the rest of that period.
- R3: If `range_i` and `reduced_i` are both high when integrate begins, integrate lasts INT_RED_CYC clocks and the reading is positive whatever `polarity_i` is. With `range_i` high and `reduced_i` low, the full INT_CYC length is used.
- R4: The counter clears on entry to de-integrate. It then adds one for every de-integrate clock whose `zero_cross_i` is low. The first clock with `zero_cross_i` high ends de-integrate, and the result is the number of low clocks.
- R5: `sign_o` (1 = negative) takes the value of `polarity_i` from the last integrate clock.
- R6: If 20000 de-integrate clocks pass with `zero_cross_i` low, de-integrate ends, the reading is 19999 and `over_o` is 1. Otherwise `over_o` is 0.
- R7: `under_o` is 1 exactly when the latched magnitude is below 1000.
- R8: With `hold_mode_i` equal to 2'b10 or 2'b11 (free-run), the display registers load at the end of every conversion.
- R9: With `hold_mode_i` equal to 2'b01 (hold), the digits, sign and flags keep their values and `status_o` stays high.
- R10: With `hold_mode_i` equal to 2'b00 (live), `digits_o` shows the running counter during de-integrate, and the final value stays latched afterwards.
- R11: `status_o` goes low on the same edge that loads the display registers and comes back high one clock later.
- R12: `digits_o` holds five BCD digits, with the most significant digit in bits [19:16]. Each lower digit is in the range 0..9, the leading digit is 0 or 1, and carries ripple correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zero_cross_i | input | 1 | Comparator reports the integrator crossing zero |
| polarity_i | input | 1 | Input polarity, 1 = negative |
| range_i | input | 1 | Range select; high enables the short-integration option |
| reduced_i | input | 1 | Request one-tenth integration (needs range_i) |
| hold_mode_i | input | 2 | 00 live, 01 hold, 10/11 free-run |
| az_o | output | 1 | Auto-zero phase active |
| int_o | output | 1 | Integrate phase active |
| deint_o | output | 1 | De-integrate phase active |
| digits_o | output | 20 | Five BCD digits of the reading |
| sign_o | output | 1 | Reading sign, 1 = negative |
| over_o | output | 1 | Reading above full scale |
| under_o | output | 1 | Reading magnitude below 1000 |
| status_o | output | 1 | Low for one clock after each display update |

## Verification
Phase outputs, the counter, the display registers and `status_o` are all registered. A comparator edge applied before clock edge k therefore shows its effects after edge k: the display load, the flags and the falling status all appear at that point. The counter value that `digits_o` shows in live mode trails the clock it counted by that same single edge. The bench changes inputs only on falling clock edges. It marks each phase change at the first falling edge where the new phase is visible and counts falling edges from that mark, so each sample is taken on the exact cycle the requirement predicts. Phase lengths and the cycle period are measured as counts of falling edges between these marks, which tests R2 and R3 down to a single clock.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int unsigned NDIG      = 5;
  localparam int unsigned DIG_W     = 4;
  localparam int unsigned CNT_W     = NDIG * DIG_W;
  localparam int unsigned MAX_COUNT = 20000;

  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    MODE_LIVE = 2'b00,
    MODE_HOLD = 2'b01,
    MODE_FREE = 2'b10,
    MODE_FREX = 2'b11
  } disp_mode_e;
endpackage

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
  import dsc_pkg::*;
#(
  parameter int unsigned INT_CYC     = 10000,
  parameter int unsigned INT_RED_CYC = 1000,
  parameter int unsigned AZ_MIN_CYC  = 1000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   range_i,
  input  logic   reduced_i,
  input  logic   polarity_i,
  input  logic   deint_end_i,
  output phase_e phase_o,
  output logic   int_last_o,
  output logic   sign_o
);
  localparam int unsigned TOTAL = AZ_MIN_CYC + INT_CYC + MAX_COUNT;
  localparam int unsigned CW    = $clog2(TOTAL);
  localparam int unsigned PW    = $clog2(INT_CYC);
  localparam logic [CW-1:0] CYC_LAST  = CW'(TOTAL - 1);
  localparam logic [CW-1:0] CYC_START = CW'(TOTAL - AZ_MIN_CYC);
  localparam logic [PW-1:0] INT_LAST  = PW'(INT_CYC - 1);
  localparam logic [PW-1:0] RED_LAST  = PW'(INT_RED_CYC - 1);

  phase_e        phase_q;
  logic [CW-1:0] cyc_q;
  logic [PW-1:0] ph_q;
  logic          red_q;
  logic          sign_q;
  logic          cyc_wrap;

  assign cyc_wrap   = (phase_q == PH_AZ) && (cyc_q == CYC_LAST);
  assign int_last_o = (phase_q == PH_INT) && (ph_q == (red_q ? RED_LAST : INT_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AZ;
      cyc_q   <= CYC_START;
      ph_q    <= '0;
      red_q   <= 1'b0;
      sign_q  <= 1'b0;
    end else begin
      cyc_q <= cyc_wrap ? '0 : cyc_q + 1'b1;
      unique case (phase_q)
        PH_AZ: begin
          if (cyc_wrap) begin
            phase_q <= PH_INT;
            ph_q    <= '0;
            red_q   <= range_i & reduced_i;
          end
        end
        PH_INT: begin
          if (int_last_o) begin
            phase_q <= PH_DEINT;
            sign_q  <= polarity_i & ~red_q;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        PH_DEINT: begin
          if (deint_end_i) phase_q <= PH_AZ;
        end
        default: phase_q <= PH_AZ;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign sign_o  = sign_q;
endmodule

// File: rtl/dsc_bcd_counter.sv
module dsc_bcd_counter
  import dsc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o
);
  logic [NDIG-1:0] carry;
  logic [NDIG-1:0] is_lim;

  assign carry[0] = inc_i;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    localparam logic [DIG_W-1:0] LIM = (i == NDIG - 1) ? DIG_W'(1) : DIG_W'(9);
    logic [DIG_W-1:0] d_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       d_q <= '0;
      else if (clr_i)    d_q <= '0;
      else if (carry[i]) d_q <= (d_q == LIM) ? '0 : d_q + 1'b1;
    end

    assign cnt_o[i*DIG_W +: DIG_W] = d_q;
    assign is_lim[i]               = (d_q == LIM);

    if (i < NDIG - 1) begin : g_carry
      assign carry[i+1] = carry[i] & is_lim[i];
    end
  end

  // leading digit limit plus all nines below it is full scale
  assign at_max_o = &is_lim;
endmodule

// File: rtl/dsc_display.sv
module dsc_display
  import dsc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             end_i,
  input  logic             timeout_i,
  input  logic             deint_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             sign_i,
  input  disp_mode_e       mode_i,
  output logic [CNT_W-1:0] digits_o,
  output logic             sign_o,
  output logic             over_o,
  output logic             under_o,
  output logic             status_o
);
  logic [CNT_W-1:0] disp_q;
  logic             sign_q, over_q, under_q, status_q;
  logic             upd, live_show, small_mag;

  assign upd       = end_i && (mode_i != MODE_HOLD);
  assign live_show = deint_i && (mode_i == MODE_LIVE);
  assign small_mag = (cnt_i[CNT_W-1 -: 2*DIG_W] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q   <= '0;
      sign_q   <= 1'b0;
      over_q   <= 1'b0;
      under_q  <= 1'b0;
      status_q <= 1'b1;
    end else begin
      status_q <= ~upd;
      if (upd) begin
        disp_q  <= cnt_i;
        sign_q  <= sign_i;
        over_q  <= timeout_i;
        under_q <= small_mag;
      end
    end
  end

  assign digits_o = live_show ? cnt_i  : disp_q;
  assign sign_o   = live_show ? sign_i : sign_q;
  assign over_o   = over_q;
  assign under_o  = under_q;
  assign status_o = status_q;
endmodule

// File: rtl/dsc_core.sv
module dsc_core
  import dsc_pkg::*;
#(
  parameter int unsigned INT_CYC     = 10000,
  parameter int unsigned INT_RED_CYC = 1000,
  parameter int unsigned AZ_MIN_CYC  = 1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        zero_cross_i,
  input  logic        polarity_i,
  input  logic        range_i,
  input  logic        reduced_i,
  input  logic [1:0]  hold_mode_i,
  output logic        az_o,
  output logic        int_o,
  output logic        deint_o,
  output logic [19:0] digits_o,
  output logic        sign_o,
  output logic        over_o,
  output logic        under_o,
  output logic        status_o
);
  phase_e           phase;
  logic             int_last, sign_cap;
  logic [CNT_W-1:0] cnt;
  logic             at_max, in_deint, deint_end, timeout, inc;

  assign in_deint  = (phase == PH_DEINT);
  assign deint_end = in_deint & (zero_cross_i | at_max);
  assign timeout   = in_deint & at_max & ~zero_cross_i;
  assign inc       = in_deint & ~zero_cross_i & ~at_max;

  dsc_sequencer #(
    .INT_CYC    (INT_CYC),
    .INT_RED_CYC(INT_RED_CYC),
    .AZ_MIN_CYC (AZ_MIN_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .range_i    (range_i),
    .reduced_i  (reduced_i),
    .polarity_i (polarity_i),
    .deint_end_i(deint_end),
    .phase_o    (phase),
    .int_last_o (int_last),
    .sign_o     (sign_cap)
  );

  dsc_bcd_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (int_last),
    .inc_i   (inc),
    .cnt_o   (cnt),
    .at_max_o(at_max)
  );

  dsc_display u_disp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .end_i    (deint_end),
    .timeout_i(timeout),
    .deint_i  (in_deint),
    .cnt_i    (cnt),
    .sign_i   (sign_cap),
    .mode_i   (disp_mode_e'(hold_mode_i)),
    .digits_o (digits_o),
    .sign_o   (sign_o),
    .over_o   (over_o),
    .under_o  (under_o),
    .status_o (status_o)
  );

  assign az_o    = (phase == PH_AZ);
  assign int_o   = (phase == PH_INT);
  assign deint_o = in_deint;
endmodule

// File: rtl/dsc_core_checker.sv
module dsc_core_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  hold_mode_i,
  input logic        az_o,
  input logic        int_o,
  input logic        deint_o,
  input logic [19:0] digits_o,
  input logic        over_o,
  input logic        under_o,
  input logic        status_o
);
  logic live_deint;
  assign live_deint = deint_o && (hold_mode_i == 2'b00);

  a_r1_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({az_o, int_o, deint_o}));

  a_r1_deint_after_int: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deint_o) |-> $past(int_o));

  a_r1_int_after_az: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_o) |-> $past(az_o));

  a_r4_clear_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(deint_o) && hold_mode_i == 2'b00) |-> digits_o == 20'h0);

  a_r6_over_full_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_o && !live_deint) |-> digits_o == 20'h19999);

  a_r7_under_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (under_o && !live_deint) |-> digits_o[19:12] == 8'h00);

  a_r9_no_update_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o |-> $past(hold_mode_i) != 2'b01);

  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o |=> status_o);

  a_r12_bcd_digits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digits_o[19:17] == 3'b000 && digits_o[15:12] <= 4'd9 && digits_o[11:8] <= 4'd9
    && digits_o[7:4] <= 4'd9 && digits_o[3:0] <= 4'd9);
endmodule

bind dsc_core dsc_core_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_mode_i(hold_mode_i),
  .az_o       (az_o),
  .int_o      (int_o),
  .deint_o    (deint_o),
  .digits_o   (digits_o),
  .over_o     (over_o),
  .under_o    (under_o),
  .status_o   (status_o)
);

// File: tb/dsc_core_test.sv
`timescale 1ns/1ps
module dsc_core_test;
  localparam int INT_CYC = 100, INT_RED = 10, AZ_MIN = 20;
  localparam int TOTAL = AZ_MIN + INT_CYC + 20000;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic zc = 1'b0, pol = 1'b0, rng = 1'b0, red = 1'b0;
  logic [1:0] mode = 2'b10;
  logic az, intg, deint, sgn, over, under, status;
  logic [19:0] digits;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dsc_core #(.INT_CYC(INT_CYC), .INT_RED_CYC(INT_RED), .AZ_MIN_CYC(AZ_MIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .zero_cross_i(zc), .polarity_i(pol),
    .range_i(rng), .reduced_i(red), .hold_mode_i(mode),
    .az_o(az), .int_o(intg), .deint_o(deint), .digits_o(digits),
    .sign_o(sgn), .over_o(over), .under_o(under), .status_o(status));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int to_bcd(int n);
    int r = 0;
    for (int i = 0; i < 5; i++) begin
      r |= (n % 10) << (4 * i);
      n /= 10;
    end
    return r;
  endfunction

  // ends at first falling edge with deint_o high
  task automatic measure_int(output int len, output int stamp);
    do @(negedge clk); while (!intg);
    stamp = cyc;
    len = 0;
    while (intg) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic finish_count(int n);
    repeat (n) @(negedge clk);
    zc = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 az after reset", az, 1);
    chk("R1 int after reset", intg, 0);
    chk("R1 deint after reset", deint, 0);
    chk("R11 status after reset", status, 1);
    chk("R6 over after reset", over, 0);
    chk("R12 digits after reset", digits, 0);
  endtask

  int stamp1;
  task automatic t_first;
    int len;
    pol = 1'b1; mode = 2'b10;
    measure_int(len, stamp1);
    chk("R2 integrate length", len, INT_CYC);
    chk("R1 deint follows int", deint, 1);
    finish_count(1000);
    chk("R11 status low on update", status, 0);
    chk("R4 count 1000", digits, to_bcd(1000));
    chk("R5 sign negative", sgn, 1);
    chk("R7 under at 1000", under, 0);
    chk("R1 az after deint", az, 1);
    zc = 1'b0;
    @(negedge clk);
    chk("R11 status back high", status, 1);
  endtask

  task automatic t_under;
    int len, stamp2;
    pol = 1'b0; mode = 2'b11;
    measure_int(len, stamp2);
    chk("R2 cycle period", stamp2 - stamp1, TOTAL);
    finish_count(500);
    chk("R8 alias free-run update", status, 0);
    chk("R4 count 500", digits, to_bcd(500));
    chk("R7 under at 500", under, 1);
    chk("R5 sign positive", sgn, 0);
    zc = 1'b0;
  endtask

  task automatic t_timeout;
    int len, st, k;
    mode = 2'b10;
    measure_int(len, st);
    k = 0;
    while (deint) begin
      k++;
      @(negedge clk);
    end
    chk("R6 deint timeout length", k, 20000);
    chk("R6 digits at timeout", digits, 'h19999);
    chk("R6 over set", over, 1);
    chk("R7 under clear", under, 0);
    chk("R11 status on timeout", status, 0);
  endtask

  task automatic t_hold;
    int len, st;
    mode = 2'b01; pol = 1'b1;
    measure_int(len, st);
    finish_count(777);
    chk("R9 no status in hold", status, 1);
    chk("R9 digits held", digits, 'h19999);
    chk("R9 over held", over, 1);
    chk("R9 sign held", sgn, 0);
    zc = 1'b0;
    @(negedge clk);
    chk("R9 status still high", status, 1);
  endtask

  task automatic t_live;
    int len, st;
    mode = 2'b00; pol = 1'b1;
    measure_int(len, st);
    chk("R4 live counter cleared", digits, 0);
    repeat (5) @(negedge clk);
    chk("R10 live count 5", digits, 5);
    chk("R10 live sign", sgn, 1);
    finish_count(37);
    chk("R10 live final", digits, to_bcd(42));
    chk("R11 live status", status, 0);
    chk("R6 over cleared", over, 0);
    chk("R7 under at 42", under, 1);
    zc = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 final kept", digits, to_bcd(42));
  endtask

  task automatic t_reduced;
    int len, st;
    mode = 2'b10; pol = 1'b1; rng = 1'b1; red = 1'b1;
    measure_int(len, st);
    chk("R3 reduced integrate length", len, INT_RED);
    finish_count(10999);
    chk("R12 carry to leading digit", digits, 'h10999);
    chk("R3 sign forced positive", sgn, 0);
    chk("R7 under at 10999", under, 0);
    zc = 1'b0;
  endtask

  task automatic t_range_only;
    int len, st;
    red = 1'b0; rng = 1'b1; pol = 1'b1;
    measure_int(len, st);
    chk("R3 range alone full length", len, INT_CYC);
    finish_count(999);
    chk("R7 under at 999", under, 1);
    chk("R3 sign kept", sgn, 1);
    chk("R12 digits 999", digits, to_bcd(999));
    zc = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!done && cyc == WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first();
    t_under();
    t_timeout();
    t_hold();
    t_live();
    t_reduced();
    t_range_only();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule